// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block models the command register of a word-wide NOR flash. It samples bus write cycles (an address and a data word) on a synchronous write strobe and decodes multi-cycle unlock sequences into operations. The operations are program, chip erase, sector erase with a timed window for more sectors, erase suspend and resume, silicon ID read, protect unlock and reset. Each accepted operation is announced by a one-cycle operation code. A program carries the latched address and data. A sector erase carries a one-hot mask of the selected sectors.

The decoder also reports the current mode: read array, ID read, busy or erase-suspended. An external array model signals the end of a program or erase with a done pulse, and a timing-limit failure with a fail level. The decoder does not model the array, the pulse timing, byte addressing or any high-voltage path. Sectors have a uniform size: the sector index is the address above bit `SECT_SHIFT`.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, mode_o is 0 (read array), op_valid_o, sect_mask_o and window_open_o are 0.
- R2: An unlock is data AAh written to address 555h followed by data 55h written to 2AAh. Only address bits 10..0 and data bits 7..0 are compared, and the other bits are don't-care.
- R3: Unlock, then A0h to 555h, then any write starts a program. On the next cycle op_valid_o is 1, op_o is 1, prog_addr_o and prog_data_o hold that write's address and data, and mode_o is 2 (busy). op_done_i returns the decoder to the mode it left.
- R4: A wrong address or data value, or a cycle out of order, returns the decoder to read array (mode 0). If an erase is suspended, it returns instead to suspend (mode 3).
- R5: Unlock, then 90h to 555h, enters ID read (mode 1). While in that mode, id_data_o is 00C2h when addr_i[0] is 0 and DEV_CODE when it is 1. A write of F0h leaves the mode.
- R6: Unlock, 80h to 555h, unlock, then 10h to 555h starts a chip erase. The outputs are op_o 2, sect_mask_o all ones and mode 2. B0h is ignored during a chip erase. op_done_i returns the decoder to mode 0 with the mask cleared.
- R7: The same six cycles ending in 30h at any address open the sector load window (window_open_o 1, mode 2). They set the mask bit that addr_i[ADDR_W-1:SECT_SHIFT] selects. Each further 30h write inside the window adds its sector to the mask.
- R8: A sector load arriving on the WINDOW_CYC-th clock after the previous load is still accepted. If no load arrives within WINDOW_CYC clocks, the window closes and the erase starts with op_o 3 and the mask unchanged. A later 30h write is then ignored.
- R9: Inside the window, B0h suspends at once (op_o 4, mode 3). Any write other than 30h or B0h returns the decoder to mode 0 and clears the mask. A write on the expiry clock takes priority over the expiry.
- R10: B0h at any address during a running sector erase suspends it (op_o 4, mode 3). 30h at any address while suspended resumes it (op_o 5, mode 2). Both commands have no effect in read array mode.
- R11: While suspended, only a program sequence is accepted. A suspend-mode program that ends with op_done_i returns the decoder to mode 3, and the sector mask is kept throughout.
- R12: While a program or erase runs, writes are ignored. The one exception is F0h written while op_fail_i is 1: it aborts to mode 0 with op_o 6 and clears the mask.
- R13: Unlock, 80h to 555h, unlock, then 20h to 555h gives op_o 7 (protect unlock) and stays in mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Bus write cycle strobe |
| addr_i | input | ADDR_W | Word address (write and ID read) |
| data_i | input | DATA_W | Write data |
| op_done_i | input | 1 | Running program or erase has finished |
| op_fail_i | input | 1 | Running operation exceeded its limits |
| mode_o | output | 2 | 0 read array, 1 ID read, 2 busy, 3 erase suspended |
| window_open_o | output | 1 | Sector load window is open |
| op_valid_o | output | 1 | One-cycle operation strobe |
| op_o | output | 3 | 1 program, 2 chip erase, 3 sector erase, 4 suspend, 5 resume, 6 abort, 7 protect unlock |
| prog_addr_o | output | ADDR_W | Latched program address |
| prog_data_o | output | DATA_W | Latched program data |
| sect_mask_o | output | NUM_SECT | Sectors selected for erase, one bit each |
| id_data_o | output | DATA_W | Identifier word in ID read mode, else 0 |

## Verification
Two events can fall on the same clock edge: the expiry of the sector load window and a bus write. After a load, the bench idles exactly WINDOW_CYC-1 clocks and then writes 30h, B0h or an unrelated value on the expiry edge. The write must win in every case: the mask grows, a suspend is reported instead of a sector erase start, or the decoder drops to read array. The bench judges each case by op_o, mode_o and sect_mask_o one clock later. A sweep of all 256 third-cycle data values and of the upper address bits checks that the decoder matches unlock cycles exactly.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    MODE_READ = 2'd0,
    MODE_ID   = 2'd1,
    MODE_BUSY = 2'd2,
    MODE_SUSP = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    OP_NONE        = 3'd0,
    OP_PROG        = 3'd1,
    OP_CHIP_ERASE  = 3'd2,
    OP_SECT_ERASE  = 3'd3,
    OP_SUSPEND     = 3'd4,
    OP_RESUME      = 3'd5,
    OP_ABORT       = 3'd6,
    OP_PROT_UNLOCK = 3'd7
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_PGM_WAIT, ST_ERS1, ST_ERS2, ST_ERS3,
    ST_ID, ST_LOAD, ST_PGM_BUSY, ST_ERS_BUSY, ST_SUSP
  } seq_e;

  typedef struct packed {
    logic at_555;
    logic at_2aa;
    logic d_aa;
    logic d_55;
    logic d_a0;
    logic d_80;
    logic d_90;
    logic d_10;
    logic d_30;
    logic d_20;
    logic d_b0;
    logic d_f0;
  } cyc_t;

  localparam int unsigned MATCH_AW = 11;
  localparam logic [MATCH_AW-1:0] UNL_ADDR_A = 11'h555;
  localparam logic [MATCH_AW-1:0] UNL_ADDR_B = 11'h2AA;

endpackage

// File: rtl/flash_cycle_match.sv
module flash_cycle_match
  import flash_cmd_pkg::*;
(
  input  logic [MATCH_AW-1:0] addr_lo_i,
  input  logic [7:0]          data_lo_i,
  output cyc_t                cyc_o
);

  always_comb begin
    cyc_o.at_555 = (addr_lo_i == UNL_ADDR_A);
    cyc_o.at_2aa = (addr_lo_i == UNL_ADDR_B);
    cyc_o.d_aa   = (data_lo_i == 8'hAA);
    cyc_o.d_55   = (data_lo_i == 8'h55);
    cyc_o.d_a0   = (data_lo_i == 8'hA0);
    cyc_o.d_80   = (data_lo_i == 8'h80);
    cyc_o.d_90   = (data_lo_i == 8'h90);
    cyc_o.d_10   = (data_lo_i == 8'h10);
    cyc_o.d_30   = (data_lo_i == 8'h30);
    cyc_o.d_20   = (data_lo_i == 8'h20);
    cyc_o.d_b0   = (data_lo_i == 8'hB0);
    cyc_o.d_f0   = (data_lo_i == 8'hF0);
  end

endmodule

// File: rtl/flash_sector_sel.sv
module flash_sector_sel #(
  parameter int unsigned ADDR_W     = 18,
  parameter int unsigned SECT_SHIFT = 15,
  localparam int unsigned SECT_W    = ADDR_W - SECT_SHIFT,
  localparam int unsigned NUM_SECT  = 1 << SECT_W
) (
  input  logic [SECT_W-1:0]   sect_idx_i,
  output logic [NUM_SECT-1:0] onehot_o
);

  for (genvar g = 0; g < NUM_SECT; g++) begin : g_sect
    assign onehot_o[g] = (sect_idx_i == SECT_W'(g));
  end

endmodule

// File: rtl/flash_load_timer.sv
module flash_load_timer #(
  parameter int unsigned WINDOW_CYC = 1500,
  localparam int unsigned CNT_W     = $clog2(WINDOW_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic expire_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || restart_i) cnt_q <= '0;
    else if (cnt_q != LAST)      cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_SECT = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   data_i,
  input  cyc_t                cyc_i,
  input  logic [NUM_SECT-1:0] sect_hot_i,
  input  logic                expire_i,
  input  logic                op_done_i,
  input  logic                op_fail_i,
  output logic                load_run_o,
  output logic                load_restart_o,
  output mode_e               mode_o,
  output logic                window_open_o,
  output logic                op_valid_o,
  output op_e                 op_o,
  output logic [ADDR_W-1:0]   prog_addr_o,
  output logic [DATA_W-1:0]   prog_data_o,
  output logic [NUM_SECT-1:0] sect_mask_o
);

  seq_e                st_q, st_d;
  logic                susp_q, susp_d;
  logic                chip_q, chip_d;
  logic [NUM_SECT-1:0] mask_q, mask_d;
  logic [ADDR_W-1:0]   pa_q, pa_d;
  logic [DATA_W-1:0]   pd_q, pd_d;
  logic                opv_q, opv_d;
  op_e                 op_q, op_d;
  seq_e                home;

  assign home = susp_q ? ST_SUSP : ST_IDLE;

  always_comb begin
    st_d           = st_q;
    susp_d         = susp_q;
    chip_d         = chip_q;
    mask_d         = mask_q;
    pa_d           = pa_q;
    pd_d           = pd_q;
    opv_d          = 1'b0;
    op_d           = OP_NONE;
    load_restart_o = 1'b0;
    case (st_q)
      ST_IDLE: if (wr_en_i && cyc_i.at_555 && cyc_i.d_aa) st_d = ST_UNL1;
      ST_ID: if (wr_en_i) st_d = (cyc_i.at_555 && cyc_i.d_aa) ? ST_UNL1 : ST_IDLE;
      ST_UNL1: if (wr_en_i) st_d = (cyc_i.at_2aa && cyc_i.d_55) ? ST_UNL2 : home;
      ST_UNL2: if (wr_en_i) begin
        if (cyc_i.at_555 && cyc_i.d_a0)                 st_d = ST_PGM_WAIT;
        else if (!susp_q && cyc_i.at_555 && cyc_i.d_80) st_d = ST_ERS1;
        else if (!susp_q && cyc_i.at_555 && cyc_i.d_90) st_d = ST_ID;
        else                                            st_d = home;
      end
      ST_PGM_WAIT: if (wr_en_i) begin
        pa_d  = addr_i;
        pd_d  = data_i;
        opv_d = 1'b1;
        op_d  = OP_PROG;
        st_d  = ST_PGM_BUSY;
      end
      ST_ERS1: if (wr_en_i) st_d = (cyc_i.at_555 && cyc_i.d_aa) ? ST_ERS2 : home;
      ST_ERS2: if (wr_en_i) st_d = (cyc_i.at_2aa && cyc_i.d_55) ? ST_ERS3 : home;
      ST_ERS3: if (wr_en_i) begin
        if (cyc_i.at_555 && cyc_i.d_10) begin
          st_d   = ST_ERS_BUSY;
          chip_d = 1'b1;
          mask_d = '1;
          opv_d  = 1'b1;
          op_d   = OP_CHIP_ERASE;
        end else if (cyc_i.d_30) begin
          st_d   = ST_LOAD;
          chip_d = 1'b0;
          mask_d = sect_hot_i;
        end else if (cyc_i.at_555 && cyc_i.d_20) begin
          st_d  = ST_IDLE;
          opv_d = 1'b1;
          op_d  = OP_PROT_UNLOCK;
        end else begin
          st_d = home;
        end
      end
      ST_LOAD: begin
        // a write on the expiry edge takes priority over the expiry
        if (wr_en_i) begin
          if (cyc_i.d_30) begin
            mask_d         = mask_q | sect_hot_i;
            load_restart_o = 1'b1;
          end else if (cyc_i.d_b0) begin
            st_d   = ST_SUSP;
            susp_d = 1'b1;
            opv_d  = 1'b1;
            op_d   = OP_SUSPEND;
          end else begin
            st_d   = ST_IDLE;
            mask_d = '0;
          end
        end else if (expire_i) begin
          st_d  = ST_ERS_BUSY;
          opv_d = 1'b1;
          op_d  = OP_SECT_ERASE;
        end
      end
      ST_PGM_BUSY: begin
        if (op_done_i) begin
          st_d = home;
        end else if (wr_en_i && cyc_i.d_f0 && op_fail_i) begin
          st_d   = ST_IDLE;
          susp_d = 1'b0;
          mask_d = '0;
          opv_d  = 1'b1;
          op_d   = OP_ABORT;
        end
      end
      ST_ERS_BUSY: begin
        if (op_done_i) begin
          st_d   = ST_IDLE;
          chip_d = 1'b0;
          mask_d = '0;
        end else if (wr_en_i && cyc_i.d_f0 && op_fail_i) begin
          st_d   = ST_IDLE;
          chip_d = 1'b0;
          mask_d = '0;
          opv_d  = 1'b1;
          op_d   = OP_ABORT;
        end else if (wr_en_i && cyc_i.d_b0 && !chip_q) begin
          st_d   = ST_SUSP;
          susp_d = 1'b1;
          opv_d  = 1'b1;
          op_d   = OP_SUSPEND;
        end
      end
      ST_SUSP: if (wr_en_i) begin
        if (cyc_i.d_30) begin
          st_d   = ST_ERS_BUSY;
          susp_d = 1'b0;
          opv_d  = 1'b1;
          op_d   = OP_RESUME;
        end else if (cyc_i.at_555 && cyc_i.d_aa) begin
          st_d = ST_UNL1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      susp_q <= 1'b0;
      chip_q <= 1'b0;
      mask_q <= '0;
      pa_q   <= '0;
      pd_q   <= '0;
      opv_q  <= 1'b0;
      op_q   <= OP_NONE;
    end else begin
      st_q   <= st_d;
      susp_q <= susp_d;
      chip_q <= chip_d;
      mask_q <= mask_d;
      pa_q   <= pa_d;
      pd_q   <= pd_d;
      opv_q  <= opv_d;
      op_q   <= op_d;
    end
  end

  always_comb begin
    case (st_q)
      ST_ID:                             mode_o = MODE_ID;
      ST_LOAD, ST_PGM_BUSY, ST_ERS_BUSY: mode_o = MODE_BUSY;
      ST_SUSP:                           mode_o = MODE_SUSP;
      default:                           mode_o = susp_q ? MODE_SUSP : MODE_READ;
    endcase
  end

  assign load_run_o    = (st_q == ST_LOAD);
  assign window_open_o = (st_q == ST_LOAD);
  assign op_valid_o    = opv_q;
  assign op_o          = op_q;
  assign prog_addr_o   = pa_q;
  assign prog_data_o   = pd_q;
  assign sect_mask_o   = mask_q;

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 18,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned SECT_SHIFT = 15,
  parameter int unsigned WINDOW_CYC = 1500,
  parameter logic [DATA_W-1:0] MFR_CODE = 16'h00C2,
  parameter logic [DATA_W-1:0] DEV_CODE = 16'h2241,
  localparam int unsigned SECT_W    = ADDR_W - SECT_SHIFT,
  localparam int unsigned NUM_SECT  = 1 << SECT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   data_i,
  input  logic                op_done_i,
  input  logic                op_fail_i,
  output logic [1:0]          mode_o,
  output logic                window_open_o,
  output logic                op_valid_o,
  output logic [2:0]          op_o,
  output logic [ADDR_W-1:0]   prog_addr_o,
  output logic [DATA_W-1:0]   prog_data_o,
  output logic [NUM_SECT-1:0] sect_mask_o,
  output logic [DATA_W-1:0]   id_data_o
);

  cyc_t                cyc;
  logic [NUM_SECT-1:0] sect_hot;
  logic                load_run, load_restart, expire;
  mode_e               mode;
  op_e                 op;

  flash_cycle_match u_match (
    .addr_lo_i (addr_i[MATCH_AW-1:0]),
    .data_lo_i (data_i[7:0]),
    .cyc_o     (cyc)
  );

  flash_sector_sel #(
    .ADDR_W     (ADDR_W),
    .SECT_SHIFT (SECT_SHIFT)
  ) u_sect (
    .sect_idx_i (addr_i[ADDR_W-1:SECT_SHIFT]),
    .onehot_o   (sect_hot)
  );

  flash_load_timer #(
    .WINDOW_CYC (WINDOW_CYC)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (load_run),
    .restart_i (load_restart),
    .expire_o  (expire)
  );

  flash_seq_fsm #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_SECT (NUM_SECT)
  ) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_en_i        (wr_en_i),
    .addr_i         (addr_i),
    .data_i         (data_i),
    .cyc_i          (cyc),
    .sect_hot_i     (sect_hot),
    .expire_i       (expire),
    .op_done_i      (op_done_i),
    .op_fail_i      (op_fail_i),
    .load_run_o     (load_run),
    .load_restart_o (load_restart),
    .mode_o         (mode),
    .window_open_o  (window_open_o),
    .op_valid_o     (op_valid_o),
    .op_o           (op),
    .prog_addr_o    (prog_addr_o),
    .prog_data_o    (prog_data_o),
    .sect_mask_o    (sect_mask_o)
  );

  assign mode_o    = mode;
  assign op_o      = op;
  assign id_data_o = (mode == MODE_ID) ? (addr_i[0] ? DEV_CODE : MFR_CODE) : '0;

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int unsigned NUM_SECT = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic [7:0]          data_lo_i,
  input logic                op_fail_i,
  input logic [1:0]          mode_o,
  input logic                window_open_o,
  input logic                op_valid_o,
  input logic [2:0]          op_o,
  input logic [NUM_SECT-1:0] sect_mask_o
);

  AST_PROG_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && op_o == 3'd1) |-> mode_o == 2'd2); // R3

  AST_CHIP_ALL_SECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && op_o == 3'd2) |-> (&sect_mask_o)); // R6

  AST_WINDOW_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    window_open_o |-> mode_o == 2'd2); // R7

  AST_WINDOW_FROM_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(window_open_o) |-> ($past(wr_en_i) && $past(data_lo_i) == 8'h30)); // R7

  AST_SECT_ON_QUIET_EXPIRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && op_o == 3'd3) |-> ($past(window_open_o) && !$past(wr_en_i))); // R8

  AST_READ_NO_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd0 || mode_o == 2'd1) |-> sect_mask_o == '0); // R9

  AST_SUSPEND_ON_B0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && op_o == 3'd4) |-> (mode_o == 2'd3 && $past(wr_en_i) && $past(data_lo_i) == 8'hB0)); // R10

  AST_RESUME_FROM_SUSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && op_o == 3'd5) |-> (mode_o == 2'd2 && $past(mode_o) == 2'd3)); // R10

  AST_SUSP_KEEPS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'd3 |-> $countones(sect_mask_o) >= 1); // R11

  AST_ABORT_NEEDS_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && op_o == 3'd6) |-> ($past(op_fail_i) && mode_o == 2'd0)); // R12

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(
  .NUM_SECT (NUM_SECT)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .data_lo_i     (data_i[7:0]),
  .op_fail_i     (op_fail_i),
  .mode_o        (mode_o),
  .window_open_o (window_open_o),
  .op_valid_o    (op_valid_o),
  .op_o          (op_o),
  .sect_mask_o   (sect_mask_o)
);

// File: tb/sim_flash_cmd_decoder.sv
`timescale 1ns/1ps
module sim_flash_cmd_decoder;

  localparam int AW = 13;
  localparam int DW = 16;
  localparam int SS = 11;
  localparam int NS = 4;
  localparam int WC = 8;
  localparam logic [15:0] DEV = 16'h2241;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic          done = 1'b0;
  logic          fail = 1'b0;
  logic [1:0]    mode;
  logic          win;
  logic          opv;
  logic [2:0]    op;
  logic [AW-1:0] paddr;
  logic [DW-1:0] pdata;
  logic [NS-1:0] mask;
  logic [DW-1:0] idd;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  flash_cmd_decoder #(
    .ADDR_W(AW), .DATA_W(DW), .SECT_SHIFT(SS), .WINDOW_CYC(WC), .DEV_CODE(DEV)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .data_i(data),
    .op_done_i(done), .op_fail_i(fail), .mode_o(mode), .window_open_o(win),
    .op_valid_o(opv), .op_o(op), .prog_addr_o(paddr), .prog_data_o(pdata),
    .sect_mask_o(mask), .id_data_o(idd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a falling edge; the write is sampled on the next rising edge
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; addr = a; data = d;
    @(negedge clk);
    wr_en = 1'b0; addr = '0; data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock();
    wr(13'h0555, 16'h00AA);
    wr(13'h02AA, 16'h0055);
  endtask

  task automatic ers_prefix();
    unlock();
    wr(13'h0555, 16'h0080);
    unlock();
  endtask

  task automatic pulse_done();
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 mode", 32'(mode), 0);
    chk("R1 op_valid", 32'(opv), 0);
    chk("R1 mask", 32'(mask), 0);
    chk("R1 window", 32'(win), 0);

    // R2 R5 sweep of third-cycle data
    for (int d = 0; d < 256; d++) begin
      unlock();
      wr(13'h0555, 16'(d));
      chk("R5 third cycle sweep", 32'(mode), (d == 8'h90) ? 1 : 0);
      wr(13'h0000, 16'h00F0);
      if (d == 8'hA0) begin
        chk("R3 sweep program start", 32'(mode), 2);
        pulse_done();
      end
      chk("R4 sweep back to read", 32'(mode), 0);
    end

    // R2 upper address and data bits are don't-care
    for (int u = 0; u < 4; u++) begin
      wr({2'(u), 11'h555}, 16'h12AA);
      wr({2'(3 - u), 11'h2AA}, 16'hFF55);
      wr({2'(u), 11'h555}, 16'h5A90);
      chk("R2 upper bits ignored", 32'(mode), 1);
      addr = {2'(u), 11'h7FE};
      #1 chk("R5 mfr code", 32'(idd), 32'h00C2);
      addr = {2'(u), 11'h001};
      #1 chk("R5 dev code", 32'(idd), 32'(DEV));
      @(negedge clk);
      wr(13'h0000, 16'h00F0);
      chk("R5 exit on F0", 32'(mode), 0);
      chk("R5 id zero outside", 32'(idd), 0);
    end

    // R4 wrong address / wrong order
    wr(13'h0555, 16'h00AA); wr(13'h02AB, 16'h0055); wr(13'h0555, 16'h0090);
    chk("R4 wrong address", 32'(mode), 0);
    wr(13'h02AA, 16'h0055); wr(13'h0555, 16'h00AA); wr(13'h0555, 16'h0090);
    chk("R4 wrong order", 32'(mode), 0);

    // R3 program
    unlock(); wr(13'h0555, 16'h00A0);
    chk("R3 waiting for data", 32'(mode), 0);
    wr(13'h1234, 16'hBEEF);
    chk("R3 op valid", 32'(opv), 1);
    chk("R3 op code", 32'(op), 1);
    chk("R3 prog addr", 32'(paddr), 32'h1234);
    chk("R3 prog data", 32'(pdata), 32'hBEEF);
    chk("R3 busy", 32'(mode), 2);
    // R12 commands ignored while busy
    unlock(); wr(13'h0555, 16'h0090);
    chk("R12 id ignored", 32'(mode), 2);
    wr(13'h0000, 16'h00F0);
    chk("R12 F0 without fail ignored", 32'(mode), 2);
    chk("R12 no op", 32'(opv), 0);
    pulse_done();
    chk("R3 done to read", 32'(mode), 0);
    // R12 abort
    unlock(); wr(13'h0555, 16'h00A0); wr(13'h0100, 16'h0001);
    fail = 1'b1;
    wr(13'h0000, 16'h00F0);
    chk("R12 abort op", 32'(op), 6);
    chk("R12 abort valid", 32'(opv), 1);
    chk("R12 abort mode", 32'(mode), 0);
    fail = 1'b0;

    // R6 chip erase
    ers_prefix(); wr(13'h0555, 16'h0010);
    chk("R6 op", 32'(op), 2);
    chk("R6 mask", 32'(mask), 32'hF);
    chk("R6 busy", 32'(mode), 2);
    wr(13'h0000, 16'h00B0);
    chk("R6 suspend ignored", 32'(mode), 2);
    chk("R6 suspend no op", 32'(opv), 0);
    pulse_done();
    chk("R6 done mode", 32'(mode), 0);
    chk("R6 done mask", 32'(mask), 0);

    // R7 R9 each sector, then reset by other command
    for (int s = 0; s < NS; s++) begin
      ers_prefix();
      wr({2'(s), 11'h123}, 16'h0030);
      chk("R7 sector bit", 32'(mask), 32'(1 << s));
      chk("R7 window open", 32'(win), 1);
      wr(13'h0000, 16'h00F0);
      chk("R9 other cmd mode", 32'(mode), 0);
      chk("R9 other cmd mask", 32'(mask), 0);
      chk("R9 window closed", 32'(win), 0);
    end

    // R8 window timing
    ers_prefix();
    wr({2'd1, 11'h040}, 16'h0030);
    idle(WC - 1);
    chk("R8 still open", 32'(win), 1);
    wr({2'd3, 11'h040}, 16'h0030);
    chk("R8 last-edge load mask", 32'(mask), 32'hA);
    idle(WC - 1);
    chk("R8 open before expiry", 32'(win), 1);
    chk("R8 no early start", 32'(opv), 0);
    idle(1);
    chk("R8 start valid", 32'(opv), 1);
    chk("R8 start op", 32'(op), 3);
    chk("R8 start mask", 32'(mask), 32'hA);
    chk("R8 window closed", 32'(win), 0);
    wr({2'd0, 11'h040}, 16'h0030);
    chk("R8 late load ignored", 32'(mask), 32'hA);
    // R10 suspend / R11 suspend behaviour
    wr(13'h0000, 16'h00B0);
    chk("R10 suspend op", 32'(op), 4);
    chk("R10 suspend mode", 32'(mode), 3);
    wr(13'h0000, 16'h00B0);
    chk("R10 second B0 no op", 32'(opv), 0);
    unlock(); wr(13'h0555, 16'h0090);
    chk("R11 id rejected", 32'(mode), 3);
    unlock(); wr(13'h0555, 16'h00A0); wr(13'h0800, 16'h1357);
    chk("R11 program op", 32'(op), 1);
    chk("R11 program busy", 32'(mode), 2);
    pulse_done();
    chk("R11 back to suspend", 32'(mode), 3);
    chk("R11 mask kept", 32'(mask), 32'hA);
    wr(13'h1FFF, 16'h0030);
    chk("R10 resume op", 32'(op), 5);
    chk("R10 resume mode", 32'(mode), 2);
    pulse_done();
    chk("R8 erase done mode", 32'(mode), 0);
    wr(13'h0000, 16'h0030);
    chk("R10 resume no effect", 32'(mode), 0);
    wr(13'h0000, 16'h00B0);
    chk("R10 suspend no effect", 32'(opv), 0);

    // R9 same-edge collisions with window expiry
    ers_prefix(); wr({2'd2, 11'h000}, 16'h0030);
    idle(WC - 1);
    wr(13'h0000, 16'h00B0);
    chk("R9 B0 beats expiry op", 32'(op), 4);
    chk("R9 B0 beats expiry mode", 32'(mode), 3);
    chk("R9 B0 beats expiry mask", 32'(mask), 32'h4);
    wr(13'h0000, 16'h0030);
    pulse_done();
    ers_prefix(); wr({2'd2, 11'h000}, 16'h0030);
    idle(WC - 1);
    wr(13'h0000, 16'h0077);
    chk("R9 other beats expiry mode", 32'(mode), 0);
    chk("R9 other beats expiry op", 32'(opv), 0);

    // R13 protect unlock
    ers_prefix(); wr(13'h0555, 16'h0020);
    chk("R13 op", 32'(op), 7);
    chk("R13 valid", 32'(opv), 1);
    chk("R13 mode", 32'(mode), 0);

    summary();
    $finish;
  end

endmodule